// File: doc/BRIEF.md
# Configurable Watchdog Reset Generator

This block is a watchdog timer behind a small register port. Software stores a timeout value in a count register and then turns counting on through a configuration register. The block counts down once per time unit. When the count runs out, it sets a sticky timeout flag and drives a reset output. That output can hold its level or give a single pulse. Its active polarity can be chosen, and in pulse mode one of four widths can be chosen.

The time base comes from a prescaler. The prescaler divides the system clock into a millisecond tick, builds a one-second unit from that tick, and builds a one-minute unit from the seconds. `TICK_DIV` sets the clocks per millisecond and `MS_PER_SEC` sets the milliseconds per second. A test build can therefore shrink both. Arming the counter restarts the prescaler, so a timeout comes a fixed number of clocks after the write that armed it.

The register port has one address bit, with the configuration register at address 0 and the count register at address 1. Writes take effect on the clock edge. Reads are combinational from `reg_addr`.

Top module: `wdog_rstgen`

## Requirements
- R1: Configuration register (address 0) layout: bit 7 reserved and reads 0; bit 6 timeout flag; bit 5 enable; bit 4 mode (1 pulse, 0 level); bit 3 unit (1 minute, 0 second); bit 2 polarity (1 active-high, 0 active-low); bits 1:0 pulse width code. Bits 5:0 read back as written. The count register (address 1) reads back its 8-bit value.
- R2: With bit 5 clear no timeout occurs. The output is inactive from one cycle after bit 5 is cleared, in either mode.
- R3: Writing bit 5 from 0 to 1 loads the counter from the count register. Writing a nonzero count while bit 5 is set reloads the counter. In both cases the timeout occurs exactly N×U clock cycles after that write's edge, where U = TICK_DIV×MS_PER_SEC, multiplied by 60 when bit 3 is 1.
- R4: The timeout sets bit 6. Writing 1 to bit 6 clears it, and writing 0 to bit 6 leaves it unchanged.
- R5: A count value of 0 never expires.
- R6: In level mode the output is active from the timeout edge until one cycle after bit 6 is cleared.
- R7: In pulse mode exactly one pulse is produced per timeout. Its length in clock cycles is TICK_DIV×W, where W is 1, 25, 125 or 5×MS_PER_SEC for width codes 0, 1, 2 and 3.
- R8: The inactive output level is the inverse of bit 2, and the active level equals bit 2.
- R9: After reset both registers read 0 and the output is high (inactive, active-low).
- R10: After a timeout the counter stays stopped until it is armed again, so clearing the flag does not start a second timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 configuration, 1 count |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| wdt_rst_o | output | 1 | Watchdog reset output |

## Verification
The prescaler and down-counter have no direct visibility at the ports, so a wrong internal state shows up as a timeout arriving on the wrong clock edge. A prescaler off by one count moves the timeout by N cycles or more. The bench therefore counts the edges from the arming write to the first active output and requires an exact match. A wrong shaper state shows up as a pulse of the wrong length or a second pulse. A stuck flag shows up within one cycle of a clearing write, either at the output or in the readback of bit 6.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W = 8;

    typedef struct packed {
        logic       stat;
        logic       en;
        logic       pulse;
        logic       unit60;
        logic       act_hi;
        logic [1:0] pw;
    } wdog_cfg_t;

    localparam logic ADDR_CFG = 1'b0;
    localparam logic ADDR_CNT = 1'b1;
    localparam int   SEC_PER_MIN = 60;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICK_DIV   = 50000,
    parameter int MS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic unit60_i,
    output logic unit_tick_o
);
    import wdog_pkg::*;

    localparam int DIV_W = $clog2(TICK_DIV + 1);
    localparam int MS_W  = $clog2(MS_PER_SEC + 1);
    localparam int SC_W  = $clog2(SEC_PER_MIN + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [MS_W-1:0]  ms;
        logic [SC_W-1:0]  sec;
    } pre_t;

    pre_t pre_d, pre_q;
    logic ms_tick, sec_tick, min_tick;

    always_comb begin
        ms_tick  = (pre_q.div == DIV_W'(TICK_DIV - 1));
        sec_tick = ms_tick && (pre_q.ms == MS_W'(MS_PER_SEC - 1));
        min_tick = sec_tick && (pre_q.sec == SC_W'(SEC_PER_MIN - 1));
        pre_d = pre_q;
        if (restart_i) begin
            pre_d = '0;
        end else begin
            pre_d.div = ms_tick ? '0 : pre_q.div + 1'b1;
            if (ms_tick)  pre_d.ms  = sec_tick ? '0 : pre_q.ms + 1'b1;
            if (sec_tick) pre_d.sec = min_tick ? '0 : pre_q.sec + 1'b1;
        end
        unit_tick_o = unit60_i ? min_tick : sec_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_shaper.sv
module wdog_shaper #(
    parameter int PW0 = 1,
    parameter int PW1 = 25,
    parameter int PW2 = 125,
    parameter int PW3 = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       en_i,
    input  logic       hold_i,
    input  logic       pulse_i,
    input  logic [1:0] pw_i,
    output logic       act_o
);
    localparam int CW = $clog2(PW3 + 1);

    typedef struct packed {
        logic          act;
        logic          pmode;
        logic [CW-1:0] cnt;
    } shp_t;

    shp_t shp_d, shp_q;
    logic [CW-1:0] load;

    always_comb begin
        case (pw_i)
            2'd0:    load = CW'(PW0 - 1);
            2'd1:    load = CW'(PW1 - 1);
            2'd2:    load = CW'(PW2 - 1);
            default: load = CW'(PW3 - 1);
        endcase
        shp_d = shp_q;
        if (!en_i) begin
            shp_d.act = 1'b0;
            shp_d.cnt = '0;
        end else if (start_i) begin
            shp_d.act   = 1'b1;
            shp_d.pmode = pulse_i;
            shp_d.cnt   = load;
        end else if (shp_q.pmode) begin
            if (shp_q.act) begin
                if (shp_q.cnt == '0) shp_d.act = 1'b0;
                else                 shp_d.cnt = shp_q.cnt - 1'b1;
            end
        end else begin
            shp_d.act = hold_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shp_q <= '0;
        else        shp_q <= shp_d;
    end

    assign act_o = shp_q.act;
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TICK_DIV   = CLK_HZ / 1000,
    parameter int MS_PER_SEC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       wdt_rst_o
);
    import wdog_pkg::*;

    localparam int PW0 = TICK_DIV;
    localparam int PW1 = 25 * TICK_DIV;
    localparam int PW2 = 125 * TICK_DIV;
    localparam int PW3 = 5 * MS_PER_SEC * TICK_DIV;

    typedef struct packed {
        wdog_cfg_t        cfg;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] remain;
    } top_t;

    top_t st_d, st_q;
    logic wr_cfg, wr_cnt, unit_tick, expire, restart;
    logic cfg_en, cfg_stat, cfg_hi, shp_act;

    always_comb begin
        wr_cfg  = reg_wr && (reg_addr == ADDR_CFG);
        wr_cnt  = reg_wr && (reg_addr == ADDR_CNT);
        expire  = st_q.cfg.en && unit_tick && (st_q.remain == REG_W'(1));
        restart = (wr_cfg && !st_q.cfg.en && reg_wdata[5]) ||
                  (wr_cnt && st_q.cfg.en);
        st_d = st_q;
        if (expire)
            st_d.remain = '0;
        else if (st_q.cfg.en && unit_tick && st_q.remain != '0)
            st_d.remain = st_q.remain - 1'b1;
        if (wr_cfg) begin
            st_d.cfg.en     = reg_wdata[5];
            st_d.cfg.pulse  = reg_wdata[4];
            st_d.cfg.unit60 = reg_wdata[3];
            st_d.cfg.act_hi = reg_wdata[2];
            st_d.cfg.pw     = reg_wdata[1:0];
            if (reg_wdata[6]) st_d.cfg.stat = 1'b0;
            if (!st_q.cfg.en && reg_wdata[5]) st_d.remain = st_q.cnt;
        end
        if (wr_cnt) begin
            st_d.cnt = reg_wdata;
            if (st_q.cfg.en) st_d.remain = reg_wdata;
        end
        if (expire) st_d.cfg.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_en   = st_q.cfg.en;
    assign cfg_stat = st_q.cfg.stat;
    assign cfg_hi   = st_q.cfg.act_hi;

    wdog_prescale #(.TICK_DIV(TICK_DIV), .MS_PER_SEC(MS_PER_SEC)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .unit60_i    (st_q.cfg.unit60),
        .unit_tick_o (unit_tick)
    );

    wdog_shaper #(.PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)) u_shp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (expire),
        .en_i    (cfg_en),
        .hold_i  (cfg_stat),
        .pulse_i (st_q.cfg.pulse),
        .pw_i    (st_q.cfg.pw),
        .act_o   (shp_act)
    );

    assign reg_rdata = (reg_addr == ADDR_CNT) ? st_q.cnt : {1'b0, st_q.cfg};
    assign wdt_rst_o = shp_act ? cfg_hi : !cfg_hi;
endmodule

// File: rtl/wdog_rstgen_chk.sv
module wdog_rstgen_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_addr,
    input logic clr_bit,
    input logic cfg_en,
    input logic cfg_stat,
    input logic cfg_hi,
    input logic expire,
    input logic shp_act,
    input logic wdt_rst_o
);
    logic clr_wr;
    assign clr_wr = reg_wr && !reg_addr && clr_bit;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_stat) && !$past(clr_wr)) |-> cfg_stat); // R4

    AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cfg_stat); // R3

    AST_FLAG_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_stat) |-> shp_act); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_en) |-> (wdt_rst_o != cfg_hi)); // R2

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_stat) |-> $past(cfg_en)); // R2
endmodule

bind wdog_rstgen wdog_rstgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .clr_bit   (reg_wdata[6]),
    .cfg_en    (cfg_en),
    .cfg_stat  (cfg_stat),
    .cfg_hi    (cfg_hi),
    .expire    (expire),
    .shp_act   (shp_act),
    .wdt_rst_o (wdt_rst_o)
);

// File: tb/sim_wdog_rstgen.sv
module sim_wdog_rstgen;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 2;
    localparam int MSPS = 50;
    localparam int SEC  = TDIV * MSPS;
    localparam int MIN  = SEC * 60;
    localparam int NV   = 9;

    localparam logic [7:0] V_CFG [NV] = '{8'h14, 8'h15, 8'h16, 8'h17, 8'h11,
                                          8'h04, 8'h00, 8'h0C, 8'h18};
    localparam logic [7:0] V_CNT [NV] = '{8'd2, 8'd1, 8'd3, 8'd2, 8'd1,
                                          8'd2, 8'd1, 8'd1, 8'd2};
    localparam int V_DLY [NV] = '{2*SEC, SEC, 3*SEC, 2*SEC, SEC,
                                  2*SEC, SEC, MIN, 2*MIN};
    localparam int V_WID [NV] = '{TDIV, 25*TDIV, 125*TDIV, 5*MSPS*TDIV, 25*TDIV,
                                  0, 0, 0, TDIV};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wdt_rst_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_rstgen #(.TICK_DIV(TDIV), .MS_PER_SEC(MSPS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_o(wdt_rst_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_level(input logic lvl, input int cap, output int t);
        t = 0;
        while (wdt_rst_o != lvl && t < cap) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int t;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd(1'b0, d); chk(d == 8'h00, "R9 cfg", d, 0);
        rd(1'b1, d); chk(d == 8'h00, "R9 cnt", d, 0);
        chk(wdt_rst_o == 1'b1, "R9 pin", wdt_rst_o, 1);

        // R1 readback, reserved bit; R5 zero count with enable
        wr(1'b0, 8'hBF);
        rd(1'b0, d); chk(d == 8'h3F, "R1 cfg readback", d, 8'h3F);
        wr(1'b1, 8'hA5);
        rd(1'b1, d); chk(d == 8'hA5, "R1 cnt readback", d, 8'hA5);
        wr(1'b1, 8'h00);
        seen = 0;
        repeat (300) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
        rd(1'b0, d); chk(!seen && !d[6], "R5 zero count", {seen, d[6]}, 0);
        wr(1'b0, 8'h40);

        // R2 no timeout while disabled
        wr(1'b1, 8'd1);
        wr(1'b0, 8'h04);
        seen = 0;
        repeat (300) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
        rd(1'b0, d); chk(!seen && !d[6], "R2 disabled", {seen, d[6]}, 0);
        wr(1'b0, 8'h40);

        // table-driven vectors: R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic hi;
            hi = V_CFG[i][2];
            wr(1'b1, V_CNT[i]);
            wr(1'b0, V_CFG[i] | 8'h20);
            chk(wdt_rst_o == !hi, "R8 inactive level", wdt_rst_o, !hi);
            wait_level(hi, V_DLY[i] + 50, t);
            chk(t == V_DLY[i], "R3 timeout delay", t, V_DLY[i]);
            rd(1'b0, d); chk(d[6], "R4 flag set", d[6], 1);
            if (V_CFG[i][4]) begin
                wait_level(!hi, V_WID[i] + 50, t);
                chk(t == V_WID[i], "R7 pulse width", t, V_WID[i]);
                seen = 0;
                repeat (30) begin @(negedge clk); if (wdt_rst_o == hi) seen = 1; end
                chk(!seen, "R7 single pulse", seen, 0);
            end else begin
                repeat (40) @(negedge clk);
                chk(wdt_rst_o == hi, "R6 level held", wdt_rst_o, hi);
                wr(1'b0, V_CFG[i] | 8'h20);
                rd(1'b0, d); chk(d[6], "R4 write zero keeps flag", d[6], 1);
                wr(1'b0, V_CFG[i] | 8'h60);
                chk(wdt_rst_o == hi, "R6 active at clear edge", wdt_rst_o, hi);
                @(negedge clk);
                chk(wdt_rst_o == !hi, "R6 released after clear", wdt_rst_o, !hi);
            end
            wr(1'b0, 8'h40);
            rd(1'b0, d); chk(d == 8'h00, "R4 flag cleared", d, 0);
        end

        // R3 reload by count write while enabled
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h24);
        repeat (150) @(negedge clk);
        chk(wdt_rst_o == 1'b0, "R3 not yet expired", wdt_rst_o, 0);
        wr(1'b1, 8'd2);
        wait_level(1'b1, 3*SEC, t);
        chk(t == 2*SEC, "R3 reload delay", t, 2*SEC);
        wr(1'b0, 8'h40);

        // R10 no second timeout after clear while still enabled
        wr(1'b1, 8'd1);
        wr(1'b0, 8'h34);
        wait_level(1'b1, 2*SEC, t);
        chk(t == SEC, "R10 first timeout", t, SEC);
        wr(1'b0, 8'h74);
        seen = 0;
        repeat (4*SEC) begin @(negedge clk); if (wdt_rst_o) seen = 1; end
        rd(1'b0, d); chk(!seen && !d[6], "R10 stays stopped", {seen, d[6]}, 0);

        // R2 disable drops pulse-mode output one cycle later
        wr(1'b1, 8'd1);
        wr(1'b0, 8'h40);
        wr(1'b0, 8'h37);
        wait_level(1'b1, 2*SEC, t);
        wr(1'b0, 8'h44);
        chk(wdt_rst_o == 1'b1, "R2 active at disable edge", wdt_rst_o, 1);
        @(negedge clk);
        chk(wdt_rst_o == 1'b0, "R2 off after disable", wdt_rst_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule